// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-facing command-block register file of a single ATA drive channel. The host writes parameters into byte-wide registers selected by a 3-bit offset, starts a command by writing the command register, and follows progress through the status byte and an interrupt line. Data words pass through a separate 16-bit data port. Toward the drive, the block announces each accepted command with a one-cycle strobe and the opcode. It forwards command-packet words on an outgoing stream, takes data-in words from an incoming stream, and waits for a completion strobe on commands that move no data through it.

The block sequences three command types. IDENTIFY returns a fixed-length block of PIO data. FLUSH CACHE, READ DMA and WRITE DMA are held busy until the drive reports completion. PACKET first collects a 12-byte command packet and then either waits for completion (DMA selected) or returns PIO data in bursts sized by a host-programmed byte-count limit.

Both streams use valid/ready. A word moves on a clock edge where both are high. The packet stream keeps `pkt_valid` and `pkt_data` steady until `pkt_ready` is seen. A host data-port write made while an earlier packet word is still waiting is dropped. The incoming stream asserts `din_ready` only while the one-word holding register is empty. The host must read a word before the next one can enter, and a data-port read while nothing is held has no effect.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status byte is 0x40 (bit 6 ready), `irq` is low, `din_ready` is low and `pkt_valid` is low.
- R2: Writes to offsets 2 to 6 read back unchanged at the same offset. Register writes made while status bit 7 (busy) is set leave the stored values unchanged.
- R3: An accepted command write (offset 7, known opcode) shows status 0xC0 for exactly one cycle. In that cycle `dev_cmd_valid` is high and `dev_cmd` carries the opcode.
- R4: IDENTIFY (0xEC) raises `irq` when the first word is held and returns ID_WORDS words in drive order. Status is 0x48 while a word is held. After the last word the status is 0x40 and no further interrupt is raised.
- R5: FLUSH CACHE (0xE7), READ DMA (0xC8) and WRITE DMA (0xCA) show status 0xC0 until `dev_done`. In the cycle after `dev_done` the status is 0x40 and `irq` is high.
- R6: A status read (offset 7) lowers `irq` by the next cycle.
- R7: An unknown opcode gives status 0x41 and raises `irq`, and offset 1 reads 0x04. The next accepted known command clears bit 0 of the status.
- R8: After the accept cycle of PACKET (0xA0), the status is 0x48. The next 6 accepted data-port writes appear on the packet stream in order, and the status then leaves 0x48.
- R9: Without DMA, PACKET data arrives in bursts of (limit >> 1) words, with a minimum of 1. The limit is {offset 5, offset 4}, captured at the accept cycle. `irq` rises when the first word of each burst is held and stays low inside a burst. The word flagged `din_last` ends the command with status 0x40 and `irq` high.
- R10: With bit 0 of offset 1 set, PACKET takes no data-in words after the packet. Status stays 0xC0 until `dev_done`, then becomes 0x40 with `irq` high.
- R11: A command write while bit 4 of offset 6 is set is ignored: no strobe, status stays 0x40, no interrupt.
- R12: `pkt_valid` and `pkt_data` hold steady while `pkt_ready` is low, and a data-port write during that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (matters at offset 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write word |
| dat_rdata | output | 16 | Held data-in word |
| irq | output | 1 | Interrupt request |
| dev_cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| dev_cmd | output | 8 | Opcode of the accepted command |
| dev_done | input | 1 | Drive completion strobe |
| din_valid | input | 1 | Incoming data word valid |
| din_ready | output | 1 | Holding register can take a word |
| din_data | input | 16 | Incoming data word |
| din_last | input | 1 | Marks the final data-in word of a packet command |
| pkt_valid | output | 1 | Packet word valid |
| pkt_ready | input | 1 | Drive accepts packet word |
| pkt_data | output | 16 | Packet word |

## Verification
PACKET runs with even, odd, zero and one-byte limits, and with totals that divide the burst size exactly, leave a short final burst, or fit in a single burst. Each of these separates a different error in burst counting, the odd-bit clearing or the minimum clamp. The packet stream is driven with the drive always ready, with a random ready pattern and with a directed stall, which shows whether words are dropped, duplicated or changed while waiting. IDENTIFY, the completion-driven commands, an unknown opcode, a command to the unselected drive and writes during busy each isolate one status sequence and one interrupt rule.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;
  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_RDY  = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;

  localparam logic [7:0] OP_IDENT  = 8'hEC;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_RDDMA  = 8'hC8;
  localparam logic [7:0] OP_WRDMA  = 8'hCA;
  localparam logic [7:0] OP_PACKET = 8'hA0;

  localparam logic [2:0] OFS_ERRFEAT = 3'd1;
  localparam logic [2:0] OFS_CMDSTAT = 3'd7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ACCEPT, PH_DEVWAIT, PH_PKTCMD, PH_DATAIN
  } phase_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_IDENT) || (op == OP_FLUSH) || (op == OP_RDDMA) ||
           (op == OP_WRDMA) || (op == OP_PACKET);
  endfunction
endpackage

// File: rtl/ata_tf_irq.sv
`timescale 1ns/1ps
module ata_tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (set)    irq_q <= 1'b1;
    else if (clr)    irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R6: a clear with no new event drops the request
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq_q);
endmodule

// File: rtl/ata_tf_regs.sv
`timescale 1ns/1ps
module ata_tf_regs import ata_tf_pkg::*; #(
  parameter int RW = 8,
  parameter int LW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [2:0]    addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  input  logic          busy,
  input  logic [RW-1:0] status,
  input  logic          err,
  output logic          feat_dma,
  output logic          drv_sel1,
  output logic [LW-1:0] word_lim,
  output logic          status_rd
);
  localparam int FIRST = 1;
  localparam int LAST  = 6;

  logic [RW-1:0]     tf_q [FIRST:LAST];
  logic [LAST:FIRST] wen;

  for (genvar g = FIRST; g <= LAST; g++) begin : g_wen
    assign wen[g] = wr && !busy && (addr == 3'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = FIRST; i <= LAST; i++) tf_q[i] <= '0;
    end else begin
      for (int i = FIRST; i <= LAST; i++)
        if (wen[i]) tf_q[i] <= wdata;
    end
  end

  always_comb begin
    case (addr)
      3'd0:        rdata = '0;
      OFS_ERRFEAT: rdata = err ? RW'(8'h04) : '0;
      OFS_CMDSTAT: rdata = status;
      default:     rdata = tf_q[addr];
    endcase
  end

  assign feat_dma  = tf_q[1][0];
  assign drv_sel1  = tf_q[6][4];
  assign word_lim  = {tf_q[5], tf_q[4][7:1]};
  assign status_rd = rd && (addr == OFS_CMDSTAT);

  // R2: stored parameters do not move while busy
  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> ($stable(word_lim) && $stable(drv_sel1) && $stable(feat_dma)));
endmodule

// File: rtl/ata_tf_seq.sv
`timescale 1ns/1ps
module ata_tf_seq import ata_tf_pkg::*; #(
  parameter int DW        = 16,
  parameter int ID_WORDS  = 256,
  parameter int PKT_WORDS = 6,
  parameter int LW        = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_code,
  input  logic          drv_sel1,
  input  logic          feat_dma,
  input  logic [LW-1:0] word_lim,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic [7:0]    status,
  output logic          busy,
  output logic          err,
  output logic          irq_set,
  output logic          cmd_take,
  output logic          dev_cmd_valid,
  output logic [7:0]    dev_cmd,
  input  logic          dev_done,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [DW-1:0] din_data,
  input  logic          din_last,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [DW-1:0] pkt_data
);
  localparam int TW = $clog2(ID_WORDS + 1);
  localparam int PW = $clog2(PKT_WORDS + 1);
  localparam int BW = (LW > TW) ? LW : TW;

  phase_e        phase_q;
  logic [7:0]    op_q;
  logic          err_q, dma_q, is_pkt_q;
  logic [DW-1:0] hold_q;
  logic          hold_v_q, hold_last_q, burst_new_q;
  logic [BW-1:0] burst_q, lim_q;
  logic [TW-1:0] total_q;
  logic [PW-1:0] pcnt_q;
  logic          pkt_v_q;
  logic [DW-1:0] pkt_d_q;

  logic known, fire, host_rd, pkt_take, word_last;

  assign known     = op_known(cmd_code);
  assign cmd_take  = cmd_wr && (phase_q == PH_IDLE) && !drv_sel1;
  assign din_ready = (phase_q == PH_DATAIN) && !hold_v_q;
  assign fire      = din_valid && din_ready;
  assign host_rd   = (phase_q == PH_DATAIN) && dat_rd && hold_v_q;
  assign pkt_take  = (phase_q == PH_PKTCMD) && dat_wr && !pkt_v_q;
  assign word_last = is_pkt_q ? hold_last_q : (total_q == TW'(1));

  assign irq_set = (cmd_take && !known) ||
                   ((phase_q == PH_DEVWAIT) && dev_done) ||
                   (fire && burst_new_q) ||
                   (host_rd && word_last && is_pkt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      op_q        <= '0;
      err_q       <= 1'b0;
      dma_q       <= 1'b0;
      is_pkt_q    <= 1'b0;
      hold_q      <= '0;
      hold_v_q    <= 1'b0;
      hold_last_q <= 1'b0;
      burst_new_q <= 1'b0;
      burst_q     <= '0;
      lim_q       <= '0;
      total_q     <= '0;
      pcnt_q      <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (cmd_take) begin
          op_q  <= cmd_code;
          err_q <= !known;
          if (known) phase_q <= PH_ACCEPT;
        end
        PH_ACCEPT: begin
          lim_q <= (word_lim == '0) ? BW'(1) : BW'(word_lim);
          dma_q <= feat_dma;
          if (op_q == OP_IDENT) begin
            phase_q     <= PH_DATAIN;
            burst_q     <= BW'(ID_WORDS);
            total_q     <= TW'(ID_WORDS);
            burst_new_q <= 1'b1;
            is_pkt_q    <= 1'b0;
          end else if (op_q == OP_PACKET) begin
            phase_q <= PH_PKTCMD;
            pcnt_q  <= '0;
          end else begin
            phase_q <= PH_DEVWAIT;
          end
        end
        PH_DEVWAIT: if (dev_done) phase_q <= PH_IDLE;
        PH_PKTCMD: if (pkt_take) begin
          pcnt_q <= pcnt_q + PW'(1);
          if (pcnt_q == PW'(PKT_WORDS - 1)) begin
            if (dma_q) phase_q <= PH_DEVWAIT;
            else begin
              phase_q     <= PH_DATAIN;
              burst_q     <= lim_q;
              burst_new_q <= 1'b1;
              is_pkt_q    <= 1'b1;
            end
          end
        end
        PH_DATAIN: begin
          if (fire) begin
            hold_q      <= din_data;
            hold_v_q    <= 1'b1;
            hold_last_q <= din_last;
            burst_new_q <= 1'b0;
          end
          if (host_rd) begin
            hold_v_q <= 1'b0;
            total_q  <= total_q - TW'(1);
            if (word_last) phase_q <= PH_IDLE;
            else if (burst_q == BW'(1)) begin
              burst_q     <= lim_q;
              burst_new_q <= 1'b1;
            end else burst_q <= burst_q - BW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_v_q <= 1'b0;
      pkt_d_q <= '0;
    end else if (pkt_take) begin
      pkt_v_q <= 1'b1;
      pkt_d_q <= dat_wdata;
    end else if (pkt_v_q && pkt_ready) begin
      pkt_v_q <= 1'b0;
    end
  end

  always_comb begin
    case (phase_q)
      PH_IDLE:    status = ST_RDY | (err_q ? ST_ERR : 8'h00);
      PH_PKTCMD:  status = ST_RDY | ST_DRQ;
      PH_DATAIN:  status = ST_RDY | (hold_v_q ? ST_DRQ : ST_BSY);
      default:    status = ST_RDY | ST_BSY;
    endcase
  end

  assign busy          = status[7];
  assign err           = err_q;
  assign dat_rdata     = hold_q;
  assign dev_cmd_valid = (phase_q == PH_ACCEPT);
  assign dev_cmd       = op_q;
  assign pkt_valid     = pkt_v_q;
  assign pkt_data      = pkt_d_q;

  // R3: the accept phase lasts one cycle
  assert_accept_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACCEPT) |=> (phase_q != PH_ACCEPT));
  // R5: completion strobe ends the busy wait
  assert_done_ends_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DEVWAIT) && dev_done) |=> (!busy && irq_set == 1'b0 || !busy));
  // R4: a taken word is presented with DRQ next cycle
  assert_fill_shows_drq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status[3]);
  // R11: commands to the unselected drive leave the block idle
  assert_drive1_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && drv_sel1 && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE && !dev_cmd_valid));
  // R12: packet word held under back-pressure
  assert_pkt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_v_q && !pkt_ready) |=> (pkt_v_q && $stable(pkt_d_q)));
endmodule

// File: rtl/ata_taskfile_ctrl.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl import ata_tf_pkg::*; #(
  parameter int DW        = 16,
  parameter int ID_WORDS  = 256,
  parameter int PKT_WORDS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          irq,
  output logic          dev_cmd_valid,
  output logic [7:0]    dev_cmd,
  input  logic          dev_done,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [DW-1:0] din_data,
  input  logic          din_last,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [DW-1:0] pkt_data
);
  localparam int LW = 15;

  logic [7:0]    status;
  logic          busy, err, feat_dma, drv_sel1, status_rd, irq_set, cmd_take;
  logic [LW-1:0] word_lim;

  ata_tf_regs #(.RW(8), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .status(status),
    .err(err), .feat_dma(feat_dma), .drv_sel1(drv_sel1),
    .word_lim(word_lim), .status_rd(status_rd)
  );

  ata_tf_seq #(.DW(DW), .ID_WORDS(ID_WORDS), .PKT_WORDS(PKT_WORDS), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(reg_wr && (reg_addr == OFS_CMDSTAT)), .cmd_code(reg_wdata),
    .drv_sel1(drv_sel1), .feat_dma(feat_dma), .word_lim(word_lim),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .status(status), .busy(busy), .err(err), .irq_set(irq_set), .cmd_take(cmd_take),
    .dev_cmd_valid(dev_cmd_valid), .dev_cmd(dev_cmd), .dev_done(dev_done),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .din_last(din_last), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data)
  );

  ata_tf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(status_rd || cmd_take), .irq(irq)
  );
endmodule

// File: tb/sim_ata_taskfile_ctrl.sv
`timescale 1ns/1ps
module sim_ata_taskfile_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, dat_wr = 0, dat_rd = 0, dev_done = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, dev_cmd;
  logic [15:0] dat_wdata = 0, dat_rdata, din_data = 0, pkt_data;
  logic irq, dev_cmd_valid, din_valid = 0, din_ready, din_last = 0;
  logic pkt_valid, pkt_ready = 1;

  ata_taskfile_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .irq(irq),
    .dev_cmd_valid(dev_cmd_valid), .dev_cmd(dev_cmd), .dev_done(dev_done),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .din_last(din_last), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] dmem [0:1023];
  int dev_n = 0, dev_idx = 0;
  bit pend = 0;
  int rdy_mode = 0;
  logic [15:0] got [0:15];
  int gotn = 0;

  // drive model: acts 2 time units after each falling edge
  initial begin
    forever begin
      @(negedge clk); #2;
      if (pend) dev_idx++;
      din_valid = (dev_idx < dev_n);
      din_data  = (dev_idx < 1024) ? dmem[dev_idx] : 16'h0;
      din_last  = (dev_idx == dev_n - 1);
      pend      = din_valid && din_ready;
      pkt_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 2);
      if (pkt_valid && pkt_ready && gotn < 16) begin got[gotn] = pkt_data; gotn++; end
    end
  end

  function automatic logic [7:0] exp_status(bit bsy, bit drq, bit err);
    return (bsy ? 8'h80 : 8'h00) | 8'h40 | (drq ? 8'h08 : 8'h00) | (err ? 8'h01 : 8'h00);
  endfunction
  function automatic int burst_words(int lim);
    return ((lim >> 1) == 0) ? 1 : (lim >> 1);
  endfunction
  function automatic logic [15:0] pat(int base, int i);
    return 16'(base * 7919 + i * 32'h1357) ^ 16'hA5A5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; @(negedge clk); reg_wr = 0;
  endtask
  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata; @(negedge clk); reg_rd = 0;
  endtask
  task automatic wdat(input logic [15:0] d);
    dat_wdata = d; dat_wr = 1; @(negedge clk); dat_wr = 0;
  endtask
  task automatic rdat(output logic [15:0] d);
    dat_rd = 1; #1 d = dat_rdata; @(negedge clk); dat_rd = 0;
  endtask
  task automatic pulse_done(); dev_done = 1; @(negedge clk); dev_done = 0; endtask
  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 200) begin tick(); n++; end
    chk(req, irq, 1);
  endtask
  task automatic dev_load(input int base, input int n);
    for (int i = 0; i < n; i++) dmem[i] = pat(base, i);
    dev_n = n; dev_idx = 0; pend = 0;
  endtask

  task automatic do_packet(input int lim, input int w, input bit dma, input bit bp, input int mode);
    logic [7:0] s; logic [15:0] d; logic [15:0] pw [0:5];
    int rem, idx, b;
    for (int k = 0; k < 6; k++) pw[k] = 16'(k * 32'h1111 + lim * 3 + w);
    dev_load(lim + 100, dma ? 0 : w);
    gotn = 0; rdy_mode = mode;
    wreg(3'd4, lim[7:0]); wreg(3'd5, lim[15:8]); wreg(3'd1, {7'd0, dma}); wreg(3'd6, 8'h40);
    wreg(3'd7, 8'hA0);
    chk("R3 strobe", dev_cmd_valid, 1); chk("R3 opcode", dev_cmd, 8'hA0);
    rreg(3'd7, s); chk("R3 accept status", s, exp_status(1, 0, 0));
    rreg(3'd7, s); chk("R8 packet drq", s, exp_status(0, 1, 0));
    for (int k = 0; k < 6; k++) begin
      int g = 0;
      while (pkt_valid && g < 100) begin tick(); g++; end
      if (bp && k == 0) begin
        rdy_mode = 2;
        wdat(pw[0]);
        chk("R12 valid", pkt_valid, 1); chk("R12 data", pkt_data, pw[0]);
        wdat(16'hDEAD);
        tick();
        chk("R12 held valid", pkt_valid, 1); chk("R12 held data", pkt_data, pw[0]);
        rdy_mode = mode;
      end else wdat(pw[k]);
    end
    begin
      int g = 0;
      while (gotn < 6 && g < 100) begin tick(); g++; end
    end
    chk("R8 packet count", gotn, 6);
    for (int k = 0; k < 6; k++) chk("R8 packet word", got[k], pw[k]);
    rdy_mode = 0;
    if (dma) begin
      tick();
      rreg(3'd7, s); chk("R10 busy", s, exp_status(1, 0, 0));
      chk("R10 no data in", din_ready, 0);
      tick(); tick();
      pulse_done();
      chk("R10 irq", irq, 1);
      rreg(3'd7, s); chk("R10 done", s, exp_status(0, 0, 0));
    end else begin
      b = burst_words(lim); rem = w; idx = 0;
      while (rem > 0) begin
        int n = (rem < b) ? rem : b;
        wait_irq("R9 burst irq");
        rreg(3'd7, s); chk("R9 burst drq", s, exp_status(0, 1, 0));
        for (int j = 0; j < n; j++) begin
          if (j == n - 1) chk("R9 quiet in burst", irq, 0);
          rdat(d); chk("R9 word", d, pat(lim + 100, idx));
          idx++;
          tick();
        end
        rem -= n;
      end
      chk("R9 final irq", irq, 1);
      rreg(3'd7, s); chk("R9 final status", s, exp_status(0, 0, 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s; logic [15:0] d;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 din_ready", din_ready, 0); chk("R1 pkt_valid", pkt_valid, 0);
    rreg(3'd7, s); chk("R1 status", s, exp_status(0, 0, 0));

    // R2 readback
    for (int a = 2; a <= 6; a++) wreg(3'(a), 8'(a * 17 + 3));
    for (int a = 2; a <= 6; a++) begin rreg(3'(a), s); chk("R2 readback", s, 8'(a * 17 + 3)); end

    // R11 unselected drive
    wreg(3'd6, 8'h10);
    wreg(3'd7, 8'hEC);
    chk("R11 no strobe", dev_cmd_valid, 0);
    tick();
    rreg(3'd7, s); chk("R11 status", s, exp_status(0, 0, 0));
    chk("R11 irq", irq, 0); chk("R11 din_ready", din_ready, 0);
    wreg(3'd6, 8'h40);

    // R4 identify
    dev_load(7, 256);
    wreg(3'd7, 8'hEC);
    chk("R3 identify strobe", dev_cmd, 8'hEC);
    wait_irq("R4 irq");
    for (int i = 0; i < 256; i++) begin
      rreg(3'd7, s); chk("R4 status drq", s, exp_status(0, 1, 0));
      rdat(d); chk("R4 word", d, pat(7, i));
      tick();
    end
    rreg(3'd7, s); chk("R4 end status", s, exp_status(0, 0, 0));
    chk("R4 no end irq", irq, 0);

    // R5 flush, R2 writes ignored while busy, R6 irq clear
    wreg(3'd3, 8'h11);
    wreg(3'd7, 8'hE7);
    chk("R3 flush strobe", dev_cmd, 8'hE7);
    rreg(3'd7, s); chk("R5 busy", s, exp_status(1, 0, 0));
    wreg(3'd3, 8'h77);
    rreg(3'd3, s); chk("R2 busy write ignored", s, 8'h11);
    rreg(3'd7, s); chk("R5 still busy", s, exp_status(1, 0, 0));
    pulse_done();
    chk("R5 irq", irq, 1);
    rreg(3'd7, s); chk("R5 done", s, exp_status(0, 0, 0));
    chk("R6 irq cleared", irq, 0);
    wreg(3'd3, 8'h77);
    rreg(3'd3, s); chk("R2 write after busy", s, 8'h77);

    // R5 read dma completion path
    wreg(3'd7, 8'hC8);
    chk("R5 rdma strobe", dev_cmd, 8'hC8);
    tick(); tick();
    rreg(3'd7, s); chk("R5 rdma busy", s, exp_status(1, 0, 0));
    pulse_done();
    chk("R5 rdma irq", irq, 1);
    rreg(3'd7, s); chk("R5 rdma done", s, exp_status(0, 0, 0));

    // R7 unknown opcode
    wreg(3'd7, 8'h55);
    chk("R7 irq", irq, 1);
    rreg(3'd1, s); chk("R7 error reg", s, 8'h04);
    rreg(3'd7, s); chk("R7 status", s, exp_status(0, 0, 1));
    chk("R6 irq cleared after error", irq, 0);
    wreg(3'd7, 8'hE7);
    rreg(3'd7, s); chk("R7 err cleared", s, exp_status(1, 0, 0));
    pulse_done();
    rreg(3'd7, s); chk("R7 recover", s, exp_status(0, 0, 0));

    // R8, R9 packet PIO directed
    do_packet(8, 10, 0, 0, 0);
    do_packet(7, 7, 0, 0, 0);
    do_packet(1, 3, 0, 0, 0);
    do_packet(0, 2, 0, 0, 0);
    do_packet(40, 5, 0, 0, 0);
    // R12 back-pressure, R10 dma
    do_packet(6, 4, 0, 1, 0);
    do_packet(6, 0, 1, 0, 0);

    // random packets with random ready
    for (int it = 0; it < 8; it++) begin
      int lim = int'($urandom % 41);
      int w   = 1 + int'($urandom % 24);
      bit dma = (($urandom % 5) == 0);
      do_packet(lim, w, dma, 0, 1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule